// File: doc/BRIEF.md
# Conversion Gain and Offset Correction Stage

This stage sits right after a 12-bit successive-approximation converter. It takes each raw sample and adjusts it using one of four stored calibration points. Each point holds a 12-bit unsigned gain and an 8-bit two's-complement offset. The point is not tied to a channel. It is found through a nine-entry map indexed by the sample's input mode (single negative, single positive, differential) and its voltage range (1.2, 2.4, 3.6 V).

The range comes from a per-input 2-bit range vector. Before correction, single-negative samples can be 1's-complemented, and so can differential samples, each under its own control bit. The corrected value saturates inside 0..4095.

A small write port loads the point registers, the map and the two inversion controls. Each sample carries a valid strobe. The result appears two cycles later with its own strobe and an error flag. There is no backpressure.

Top module: `cal_corr_top`

## Requirements
- R1: Point register k (write address k, 0..3) holds the gain in bits 11:0 and the signed offset in bits 19:12. Every point resets to gain 0x555 and offset 0.
- R2: The map register (write address 4) holds nine 2-bit fields. Field f sits in bits 2f+1:2f, with f = 3*range_index + mode_index. Mode index is 0 for single negative, 1 for single positive and 2 for differential. Range index is 0 for 1.2 V, 1 for 2.4 V and 2 for 3.6 V. A field value v selects point v. The map resets to 0.
- R3: Channel codes map to mode and range slot as follows. Codes 0..3 are single negative on input k = code, using slot k. Codes 4..7 are single positive, using slot code (4..7). Codes 8..11 are differential on pair code-8, using slot code-8. Slot s is smp_range_i[2s+1:2s].
- R4: Code 12 (battery) always uses single negative at 3.6 V. Code 13 (temperature) always uses single positive at 1.2 V. Neither reads the range vector.
- R5: Range code 00 is 1.2 V, 10 is 2.4 V and 11 is 3.6 V. Code 01 is reserved.
- R6: The control register (write address 5) bit 0 enables 1's-complement of single-negative samples before correction. This bit resets to 1.
- R7: Control bit 1 enables 1's-complement of differential samples. This bit resets to 0. Single-positive samples are never inverted.
- R8: The corrected value is ((x*gain)>>11) + offset, clamped to 0..4095, where x is the sample after any inversion.
- R9: A reserved channel code (14, 15) or a reserved range code passes the raw sample out unchanged, with no inversion, and asserts err_o with valid_o. err_o is low whenever valid_o is low.
- R10: valid_o follows smp_valid_i two cycles later, one sample per cycle. data_o holds its value while valid_o is low. All outputs reset to 0.
- R11: Writes to addresses 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| smp_valid_i | input | 1 | Raw sample valid |
| smp_raw_i | input | 12 | Raw converter sample |
| smp_chan_i | input | 4 | Channel code of the sample |
| smp_range_i | input | 16 | Eight 2-bit range codes, one per input slot |
| valid_o | output | 1 | Corrected sample valid |
| data_o | output | 12 | Corrected sample |
| err_o | output | 1 | Reserved channel or range seen on this sample |

## Verification
Each corrected sample, together with its error flag, appears two rising edges after the edge that accepts the input. Configuration writes take effect from the edge that captures them. The bench drives on falling edges and reads single results on the second falling edge after driving. In the streaming test it compares the output at every falling edge against the sample driven two falling edges earlier. Expected values come from a model of the requirements that tracks every configuration write.

// File: rtl/cal_corr_pkg.sv
package cal_corr_pkg;
  typedef enum logic [1:0] {
    MODE_SN   = 2'd0,
    MODE_SP   = 2'd1,
    MODE_DIFF = 2'd2
  } in_mode_e;

  localparam int unsigned N_MODES  = 3;
  localparam int unsigned N_RANGES = 3;
  localparam int unsigned N_FIELDS = N_MODES * N_RANGES;
endpackage

// File: rtl/cal_cfg_regs.sv
module cal_cfg_regs #(
  parameter int unsigned GAIN_W   = 12,
  parameter int unsigned OFS_W    = 8,
  parameter int unsigned N_POINTS = 4,
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned ADDR_W   = 3,
  parameter logic [GAIN_W-1:0] GAIN_RST = 12'h555,
  localparam int unsigned PT_W    = $clog2(N_POINTS),
  localparam int unsigned MAP_W   = cal_corr_pkg::N_FIELDS * PT_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [CFG_W-1:0]             wdata_i,
  output logic [N_POINTS*GAIN_W-1:0]   gain_o,
  output logic [N_POINTS*OFS_W-1:0]    ofs_o,
  output logic [MAP_W-1:0]             map_o,
  output logic                         inv_sn_o,
  output logic                         inv_diff_o
);
  localparam int unsigned MAP_ADDR  = N_POINTS;
  localparam int unsigned CTRL_ADDR = N_POINTS + 1;

  for (genvar i = 0; i < N_POINTS; i++) begin : g_pt
    logic [GAIN_W-1:0] gain_q;
    logic [OFS_W-1:0]  ofs_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gain_q <= GAIN_RST;
        ofs_q  <= '0;
      end else if (we_i && addr_i == ADDR_W'(i)) begin
        gain_q <= wdata_i[GAIN_W-1:0];
        ofs_q  <= wdata_i[GAIN_W+OFS_W-1:GAIN_W];
      end
    end
    assign gain_o[i*GAIN_W +: GAIN_W] = gain_q;
    assign ofs_o[i*OFS_W +: OFS_W]    = ofs_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_o      <= '0;
      inv_sn_o   <= 1'b1;
      inv_diff_o <= 1'b0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(MAP_ADDR)) map_o <= wdata_i[MAP_W-1:0];
      if (addr_i == ADDR_W'(CTRL_ADDR)) begin
        inv_sn_o   <= wdata_i[0];
        inv_diff_o <= wdata_i[1];
      end
    end
  end
endmodule

// File: rtl/cal_select.sv
module cal_select
  import cal_corr_pkg::*;
#(
  parameter int unsigned N_EXT    = 8,
  parameter int unsigned N_POINTS = 4,
  parameter int unsigned CH_W     = 4,
  localparam int unsigned PT_W    = $clog2(N_POINTS),
  localparam int unsigned MAP_W   = N_FIELDS * PT_W
) (
  input  logic [CH_W-1:0]    chan_i,
  input  logic [2*N_EXT-1:0] range_i,
  input  logic [MAP_W-1:0]   map_i,
  input  logic               inv_sn_i,
  input  logic               inv_diff_i,
  output logic [PT_W-1:0]    pt_o,
  output logic               invert_o,
  output logic               bypass_o
);
  localparam int unsigned HALF   = N_EXT / 2;
  localparam int unsigned IDX_W  = $clog2(N_EXT);
  localparam int unsigned FLD_W  = $clog2(N_FIELDS);
  localparam int unsigned CH_BAT = N_EXT + HALF;
  localparam int unsigned CH_TMP = N_EXT + HALF + 1;

  in_mode_e         mode;
  logic [IDX_W-1:0] slot;
  logic             fixed_rng;
  logic [1:0]       fixed_idx;
  logic             chan_bad;
  logic [1:0]       rcode;
  logic [1:0]       rng_idx;
  logic             rng_bad;
  logic [FLD_W-1:0] field;

  always_comb begin
    mode      = MODE_SN;
    slot      = '0;
    fixed_rng = 1'b0;
    fixed_idx = 2'd0;
    chan_bad  = 1'b0;
    if (chan_i < CH_W'(HALF)) begin
      mode = MODE_SN;
      slot = IDX_W'(chan_i);
    end else if (chan_i < CH_W'(N_EXT)) begin
      mode = MODE_SP;
      slot = IDX_W'(chan_i);
    end else if (chan_i < CH_W'(CH_BAT)) begin
      mode = MODE_DIFF;
      slot = IDX_W'(chan_i - CH_W'(N_EXT));
    end else if (chan_i == CH_W'(CH_BAT)) begin
      mode      = MODE_SN;
      fixed_rng = 1'b1;
      fixed_idx = 2'd2;
    end else if (chan_i == CH_W'(CH_TMP)) begin
      mode      = MODE_SP;
      fixed_rng = 1'b1;
      fixed_idx = 2'd0;
    end else begin
      chan_bad = 1'b1;
    end
  end

  assign rcode = range_i[2*slot +: 2];

  always_comb begin
    rng_bad = 1'b0;
    unique case (rcode)
      2'b00:   rng_idx = 2'd0;
      2'b10:   rng_idx = 2'd1;
      2'b11:   rng_idx = 2'd2;
      default: begin
        rng_idx = 2'd0;
        rng_bad = 1'b1;
      end
    endcase
    if (fixed_rng) begin
      rng_idx = fixed_idx;
      rng_bad = 1'b0;
    end
  end

  assign field    = FLD_W'(rng_idx) * FLD_W'(N_MODES) + FLD_W'(mode);
  assign pt_o     = map_i[PT_W*field +: PT_W];
  assign bypass_o = chan_bad | rng_bad;
  assign invert_o = !bypass_o &&
                    ((mode == MODE_SN && inv_sn_i) || (mode == MODE_DIFF && inv_diff_i));
endmodule

// File: rtl/cal_arith.sv
module cal_arith #(
  parameter int unsigned RAW_W      = 12,
  parameter int unsigned GAIN_W     = 12,
  parameter int unsigned OFS_W      = 8,
  parameter int unsigned GAIN_SHIFT = 11
) (
  input  logic [RAW_W-1:0]  raw_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              bypass_i,
  output logic [RAW_W-1:0]  data_o
);
  localparam int unsigned PROD_W = RAW_W + GAIN_W;
  localparam int unsigned SH_W   = PROD_W - GAIN_SHIFT;
  localparam int unsigned SUM_W  = SH_W + 2;
  localparam logic [SUM_W-1:0] MAX_CODE = SUM_W'((1 << RAW_W) - 1);

  logic [PROD_W-1:0] prod;
  logic [SH_W-1:0]   scaled;
  logic [SUM_W-1:0]  sum;

  assign prod   = PROD_W'(raw_i) * PROD_W'(gain_i);
  assign scaled = prod[PROD_W-1:GAIN_SHIFT];
  assign sum    = {2'b00, scaled} + {{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};

  always_comb begin
    if (bypass_i)            data_o = raw_i;
    else if (sum[SUM_W-1])   data_o = '0;
    else if (sum > MAX_CODE) data_o = MAX_CODE[RAW_W-1:0];
    else                     data_o = sum[RAW_W-1:0];
  end
endmodule

// File: rtl/cal_corr_top.sv
module cal_corr_top #(
  parameter int unsigned RAW_W      = 12,
  parameter int unsigned GAIN_W     = 12,
  parameter int unsigned OFS_W      = 8,
  parameter int unsigned GAIN_SHIFT = 11,
  parameter int unsigned N_POINTS   = 4,
  parameter int unsigned N_EXT      = 8,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned CFG_W      = 32,
  parameter int unsigned ADDR_W     = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               smp_valid_i,
  input  logic [RAW_W-1:0]   smp_raw_i,
  input  logic [CH_W-1:0]    smp_chan_i,
  input  logic [2*N_EXT-1:0] smp_range_i,
  output logic               valid_o,
  output logic [RAW_W-1:0]   data_o,
  output logic               err_o
);
  localparam int unsigned PT_W  = $clog2(N_POINTS);
  localparam int unsigned MAP_W = cal_corr_pkg::N_FIELDS * PT_W;

  logic [N_POINTS*GAIN_W-1:0] gain_all;
  logic [N_POINTS*OFS_W-1:0]  ofs_all;
  logic [MAP_W-1:0]           map;
  logic                       inv_sn, inv_diff;
  logic [PT_W-1:0]            pt;
  logic                       invert, bypass;

  cal_cfg_regs #(
    .GAIN_W(GAIN_W), .OFS_W(OFS_W), .N_POINTS(N_POINTS),
    .CFG_W(CFG_W), .ADDR_W(ADDR_W), .GAIN_RST(GAIN_W'(12'h555))
  ) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .gain_o(gain_all), .ofs_o(ofs_all), .map_o(map),
    .inv_sn_o(inv_sn), .inv_diff_o(inv_diff)
  );

  cal_select #(.N_EXT(N_EXT), .N_POINTS(N_POINTS), .CH_W(CH_W)) i_sel (
    .chan_i(smp_chan_i), .range_i(smp_range_i), .map_i(map),
    .inv_sn_i(inv_sn), .inv_diff_i(inv_diff),
    .pt_o(pt), .invert_o(invert), .bypass_o(bypass)
  );

  // stage 1: selected point and conditioned sample
  logic              s1_valid, s1_bypass;
  logic [RAW_W-1:0]  s1_raw;
  logic [GAIN_W-1:0] s1_gain;
  logic [OFS_W-1:0]  s1_ofs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid  <= 1'b0;
      s1_bypass <= 1'b0;
      s1_raw    <= '0;
      s1_gain   <= '0;
      s1_ofs    <= '0;
    end else begin
      s1_valid <= smp_valid_i;
      if (smp_valid_i) begin
        s1_bypass <= bypass;
        s1_raw    <= invert ? ~smp_raw_i : smp_raw_i;
        s1_gain   <= gain_all[pt*GAIN_W +: GAIN_W];
        s1_ofs    <= ofs_all[pt*OFS_W +: OFS_W];
      end
    end
  end

  logic [RAW_W-1:0] corr;

  cal_arith #(
    .RAW_W(RAW_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W), .GAIN_SHIFT(GAIN_SHIFT)
  ) i_arith (
    .raw_i(s1_raw), .gain_i(s1_gain), .ofs_i(s1_ofs),
    .bypass_i(s1_bypass), .data_o(corr)
  );

  // stage 2: output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= s1_valid;
      err_o   <= s1_valid & s1_bypass;
      if (s1_valid) data_o <= corr;
    end
  end
endmodule

// File: rtl/cal_corr_chk.sv
module cal_corr_chk #(
  parameter int unsigned RAW_W = 12,
  parameter int unsigned CH_W  = 4,
  parameter int unsigned N_EXT = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               smp_valid_i,
  input logic [RAW_W-1:0]   smp_raw_i,
  input logic [CH_W-1:0]    smp_chan_i,
  input logic [2*N_EXT-1:0] smp_range_i,
  input logic               valid_o,
  input logic [RAW_W-1:0]   data_o,
  input logic               err_o
);
  logic rsvd_chan, sp_rng_bad, fixed_chan;
  assign rsvd_chan  = smp_chan_i >= CH_W'(N_EXT + N_EXT/2 + 2);
  assign sp_rng_bad = smp_chan_i >= CH_W'(N_EXT/2) && smp_chan_i < CH_W'(N_EXT) &&
                      smp_range_i[2*smp_chan_i +: 2] == 2'b01;
  assign fixed_chan = smp_chan_i == CH_W'(N_EXT + N_EXT/2) ||
                      smp_chan_i == CH_W'(N_EXT + N_EXT/2 + 1);

  assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |-> ##2 valid_o);
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |-> ##2 !valid_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
  assert_err_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o);
  assert_rsvd_chan_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && rsvd_chan) |-> ##2 (err_o && data_o == $past(smp_raw_i, 2)));
  assert_rsvd_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && sp_rng_bad) |-> ##2 err_o);
  assert_fixed_chan_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && fixed_chan) |-> ##2 !err_o);
endmodule

bind cal_corr_top cal_corr_chk #(.RAW_W(RAW_W), .CH_W(CH_W), .N_EXT(N_EXT)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i), .smp_raw_i(smp_raw_i),
  .smp_chan_i(smp_chan_i), .smp_range_i(smp_range_i), .valid_o(valid_o),
  .data_o(data_o), .err_o(err_o)
);

// File: tb/test_cal_corr_top.sv
module test_cal_corr_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        smp_valid_i = 1'b0;
  logic [11:0] smp_raw_i = '0;
  logic [3:0]  smp_chan_i = '0;
  logic [15:0] smp_range_i = '0;
  logic        valid_o;
  logic [11:0] data_o;
  logic        err_o;

  int n_chk = 0;
  int n_bad = 0;

  int sh_gain [4];
  int sh_ofs  [4];
  logic [17:0] sh_map;
  logic sh_inv_sn, sh_inv_diff;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cal_corr_top i_cal_corr_top (.*);

  function automatic int model(input int raw, input int ch, input logic [15:0] rng);
    int mode, slot, r, f, p, x, v;
    logic [1:0] rc;
    slot = 0; r = 0;
    if (ch < 4)       begin mode = 0; slot = ch; end
    else if (ch < 8)  begin mode = 1; slot = ch; end
    else if (ch < 12) begin mode = 2; slot = ch - 8; end
    else if (ch == 12) begin mode = 0; r = 2; end
    else if (ch == 13) begin mode = 1; r = 0; end
    else return 4096 + raw;
    if (ch < 12) begin
      rc = rng[2*slot +: 2];
      if (rc == 2'b01) return 4096 + raw;
      r = (rc == 2'b00) ? 0 : (rc == 2'b10) ? 1 : 2;
    end
    f = r * 3 + mode;
    p = int'(sh_map[2*f +: 2]);
    x = raw;
    if ((mode == 0 && sh_inv_sn) || (mode == 2 && sh_inv_diff)) x = 4095 - raw;
    v = ((x * sh_gain[p]) >>> 11) + sh_ofs[p];
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic check(input string tag, input logic gv, input logic ge, input int gd,
                       input logic ev, input logic ee, input int ed);
    n_chk++;
    if (gv !== ev || ge !== ee || gd != ed) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b err=%0b data=%0d, expected valid=%0b err=%0b data=%0d",
               tag, gv, ge, gd, ev, ee, ed);
    end
  endtask

  task automatic cfg_write(input int addr, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 3'(addr); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (addr < 4) begin
      sh_gain[addr] = int'(d[11:0]);
      sh_ofs[addr]  = int'($signed(d[19:12]));
    end else if (addr == 4) sh_map = d[17:0];
    else if (addr == 5) begin sh_inv_sn = d[0]; sh_inv_diff = d[1]; end
  endtask

  task automatic one_sample(input string tag, input int raw, input int ch, input logic [15:0] rng);
    int e;
    @(negedge clk_i);
    smp_valid_i = 1'b1; smp_raw_i = 12'(raw); smp_chan_i = 4'(ch); smp_range_i = rng;
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    @(negedge clk_i);
    e = model(raw, ch, rng);
    check(tag, valid_o, err_o, int'(data_o), 1'b1, e >= 4096, e % 4096);
  endtask

  task automatic t_reset;
    check("R10 reset outputs", valid_o, err_o, int'(data_o), 1'b0, 1'b0, 0);
    // R1 reset gain 0x555: 0xC00*0x555>>11 = 2047
    one_sample("R1 reset point sp", 12'hC00, 4, 16'h0000);
    check("R1 reset value", 1'b1, 1'b0, int'(data_o), 1'b1, 1'b0, 2047);
    // R6 reset invert on single negative: (4095-0x100)*0x555>>11
    one_sample("R6 reset sn inversion", 12'h100, 0, 16'h0000);
    check("R6 reset sn value", 1'b1, 1'b0, int'(data_o), 1'b1, 1'b0, ((4095-256)*1365)>>>11);
    one_sample("R7 reset diff no inversion", 12'h100, 9, 16'h0000);
  endtask

  task automatic t_map;
    logic [17:0] m;
    logic [1:0]  codes [3];
    codes[0] = 2'b00; codes[1] = 2'b10; codes[2] = 2'b11;
    cfg_write(0, {12'h0, 8'd0,   12'h800});
    cfg_write(1, {12'h0, 8'd10,  12'h800});
    cfg_write(2, {12'h0, 8'hFB,  12'h400});
    cfg_write(3, {12'h0, 8'h20,  12'hC00});
    m = '0;
    for (int f = 0; f < 9; f++) m[2*f +: 2] = 2'((f * 3 + 1) % 4);
    cfg_write(4, {14'h0, m});
    for (int c = 0; c < 3; c++)
      for (int ch = 0; ch < 12; ch++)
        one_sample($sformatf("R2 R3 R5 ch=%0d code=%0b", ch, codes[c]),
                   300 + ch * 17, ch, {8{codes[c]}});
    // R3: slot selection, only slot 6 set to 3.6 V
    one_sample("R3 slot of code 6", 1000, 6, 16'h3000);
    one_sample("R3 slot of code 2", 1000, 2, 16'h0030);
    one_sample("R3 diff pair 3 slot", 1000, 11, 16'h00C0);
  endtask

  task automatic t_fixed;
    one_sample("R4 battery ignores range", 2000, 12, 16'h5555);
    one_sample("R4 temperature ignores range", 2000, 13, 16'h5555);
  endtask

  task automatic t_invert;
    cfg_write(5, 32'h2);
    one_sample("R6 sn not inverted", 1234, 1, 16'h0000);
    one_sample("R7 diff inverted", 1234, 8, 16'h0000);
    one_sample("R7 sp never inverted", 1234, 5, 16'h0000);
    cfg_write(5, 32'h3);
    one_sample("R6 sn inverted", 1234, 3, 16'h0000);
  endtask

  task automatic t_clamp;
    cfg_write(3, {12'h0, 8'h7F, 12'hFFF});
    cfg_write(4, {14'h0, {9{2'b11}}});
    cfg_write(5, 32'h0);
    one_sample("R8 clamp high", 4095, 4, 16'h0000);
    cfg_write(3, {12'h0, 8'h80, 12'h800});
    one_sample("R8 clamp low", 50, 4, 16'h0000);
    one_sample("R8 negative offset", 1000, 4, 16'h0000);
    cfg_write(3, {12'h0, 8'h05, 12'h800});
    one_sample("R8 unity plus offset", 4090, 5, 16'h0000);
  endtask

  task automatic t_reserved;
    cfg_write(5, 32'h3);
    one_sample("R9 chan 14", 777, 14, 16'h0000);
    one_sample("R9 chan 15", 3333, 15, 16'h0000);
    one_sample("R9 R5 reserved range sp", 555, 5, 16'h0400);
    one_sample("R9 R5 reserved range sn no invert", 555, 0, 16'h0001);
  endtask

  task automatic t_ignored_addr;
    cfg_write(6, 32'hFFFF_FFFF);
    cfg_write(7, 32'h0000_0000);
    // shadow unchanged: outputs must still follow prior configuration
    one_sample("R11 addr 6/7 ignored sp", 1500, 4, 16'h0000);
    one_sample("R11 addr 6/7 ignored sn", 1500, 0, 16'h0000);
  endtask

  task automatic t_stream;
    int n = 24;
    int exp_q [24];
    logic [11:0] last;
    cfg_write(0, {12'h0, 8'hF0, 12'h900});
    cfg_write(1, {12'h0, 8'h11, 12'h700});
    cfg_write(4, {14'h0, 18'h1B1E4});
    last = data_o;
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2)
        check($sformatf("R10 stream %0d", i - 2), valid_o, err_o, int'(data_o),
              1'b1, exp_q[i-2] >= 4096, exp_q[i-2] % 4096);
      if (i < n) begin
        smp_valid_i = 1'b1;
        smp_raw_i   = 12'((i * 613 + 91) % 4096);
        smp_chan_i  = 4'(i % 16);
        smp_range_i = 16'((i * 40503) % 65536);
        exp_q[i]    = model(int'(smp_raw_i), int'(smp_chan_i), smp_range_i);
        if (exp_q[i] % 4096 >= 0) last = 12'(exp_q[i] % 4096);
      end else smp_valid_i = 1'b0;
    end
    @(negedge clk_i);
    check("R10 idle after stream", valid_o, err_o, int'(data_o), 1'b0, 1'b0, int'(last));
    repeat (3) @(negedge clk_i);
    check("R10 data holds", valid_o, err_o, int'(data_o), 1'b0, 1'b0, int'(last));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got running, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin sh_gain[i] = 12'h555; sh_ofs[i] = 0; end
    sh_map = '0; sh_inv_sn = 1'b1; sh_inv_diff = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R10 outputs in reset", valid_o, err_o, int'(data_o), 1'b0, 1'b0, 0);
    rst_ni = 1'b1;
    t_reset;
    t_map;
    t_fixed;
    t_invert;
    t_clamp;
    t_reserved;
    t_ignored_addr;
    t_stream;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule